// File: doc/BRIEF.md
# DRAM Bank State and Idle-Time Tracker

This block keeps the bookkeeping a DRAM controller needs for every bank of every rank: which row is open, the cycle at which the bank is next free, and the earliest cycle at which its open row may be closed. A scheduler elsewhere issues one event per clock, either a column access or an explicit close. Each event carries the rank, the bank, the row, the current cycle and the cycle at which the access's data completes. The tracker applies the row-buffer rules that follow from the selected page policy and the fixed timing parameters. A row miss closes the old row and then opens the new one. An access may close its row straight afterwards, and under the closed-page policy every access does.

Besides the per-bank state, the block counts how many banks hold an open row. It also measures the time the whole device sits with every bank closed. When the last open bank closes, the later of the stored start time and that bank's close-completion cycle is latched as the start of an idle stretch. The next activation that occurs after that point adds the gap to a running total. On every row close, the byte count and access count gathered while that row was open are presented on a one-cycle strobe. This lets bytes per activation be observed.

All outputs are registered. Effects of an event issued on a clock edge are visible after that edge.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank holds the reserved empty-row value (all ones in the row field), busy-until and close-allowed cycles are 0, the open-bank count is 0, and the idle start and idle total are 0.
- R2: An access event (op code 1) on a bank that is empty or holds another row, under the open-page policy (`pol_closed` low) and without auto-close, stores the row and sets busy-until to the supplied completion cycle. It sets the close-allowed cycle to completion minus T_CL minus T_RCD plus T_RAS and raises the open-bank count by one.
- R3: An access to the row already open in that bank (open-page policy) updates busy-until only. The row, the close-allowed cycle and the count stay unchanged, while the bank's byte and access counters keep accumulating.
- R4: An access that misses on a bank with an open row first closes that row, with completion at the latest of busy-until, close-allowed cycle and the current cycle, plus T_RP. The close strobe reports the closed row's accumulated bytes and accesses.
- R5: A close event (op code 2) on an open bank empties it and sets busy-until to the latest of busy-until, close-allowed cycle and the current cycle, plus T_RP. It lowers the count by one and raises the close strobe.
- R6: A close event on a bank that holds no row changes no bank state and no count, and raises no strobe.
- R7: An access with auto-close set performs the access and then empties the bank, with busy-until set to the later of the completion cycle and the new close-allowed cycle, plus T_RP. The count ends unchanged by the pair, and the auto-close strobe reports the row's bytes and accesses.
- R8: Under the closed-page policy every access activates and then auto-closes as in R7, so the count never rises.
- R9: When the count falls to zero, the idle start becomes the later of its current value and the completion cycle of the close that emptied the last bank.
- R10: An activation that happens while no other bank is open adds its activate cycle minus the idle start to the idle total, if that cycle lies after the idle start. Otherwise the total is unchanged.
- R11: The open-bank count never exceeds RANKS times BANKS and moves by at most one per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_closed | input | 1 | 1 selects closed-page policy, 0 open-page |
| cmd_op | input | 2 | 0 none, 1 access, 2 close, 3 treated as none |
| cmd_rank | input | RK_W | Target rank |
| cmd_bank | input | BK_W | Target bank within the rank |
| cmd_row | input | ROW_W | Row of an access (never all ones) |
| cmd_now | input | TW | Current cycle stamp |
| cmd_free_at | input | TW | Completion cycle of the access |
| cmd_auto | input | 1 | Close the row right after this access |
| cmd_bytes | input | BYTE_W | Bytes moved by this access |
| bank_row | output | NB*ROW_W | Open row of bank i at slice i, i = rank*BANKS+bank |
| bank_busy | output | NB*TW | Busy-until cycle per bank |
| bank_tras | output | NB*TW | Earliest close cycle per bank |
| act_count | output | CNT_W | Number of banks holding a row |
| idle_since | output | TW | Start of the current all-closed stretch |
| idle_total | output | TW | Accumulated all-closed cycles |
| evict_vld | output | 1 | A row was closed by a miss or a close event |
| evict_bytes | output | BYTE_W | Bytes accumulated by that row |
| evict_accs | output | ACC_W | Accesses made to that row |
| auto_vld | output | 1 | A row was closed by auto-close |
| auto_bytes | output | BYTE_W | Bytes accumulated by that row |
| auto_accs | output | ACC_W | Accesses made to that row |

## Verification
The checks rely on the scheduler never sending the all-ones row value with an access, and on each access completing at least T_CL plus T_RCD cycles after its stamp. They also assume cycle stamps never decrease and that rank and bank stay within their ranges. The directed scenarios stamp every event with a rising cycle value and choose completion cycles well clear of the activate lead. They address only existing banks, so the assumption checks stay quiet. Open-bank closes, closes of empty banks, misses with auto-close in one event and activations that land before the idle start are all driven deliberately.

// File: rtl/bst_pkg.sv
package bst_pkg;
   typedef enum logic [1:0] {
      OP_NONE      = 2'd0,
      OP_ACCESS    = 2'd1,
      OP_PRECHARGE = 2'd2,
      OP_RSVD      = 2'd3
   } bst_op_e;
endpackage

// File: rtl/bst_bank_file.sv
module bst_bank_file #(
   parameter int NB     = 8,
   parameter int IDX_W  = 3,
   parameter int ROW_W  = 14,
   parameter int TW     = 32,
   parameter int BYTE_W = 16,
   parameter int ACC_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [ROW_W-1:0]    wr_row,
   input  logic [TW-1:0]       wr_busy,
   input  logic [TW-1:0]       wr_tras,
   input  logic [BYTE_W-1:0]   wr_bytes,
   input  logic [ACC_W-1:0]    wr_accs,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [ROW_W-1:0]    rd_row,
   output logic [TW-1:0]       rd_busy,
   output logic [TW-1:0]       rd_tras,
   output logic [BYTE_W-1:0]   rd_bytes,
   output logic [ACC_W-1:0]    rd_accs,
   output logic [NB*ROW_W-1:0] all_row,
   output logic [NB*TW-1:0]    all_busy,
   output logic [NB*TW-1:0]    all_tras
);
   localparam logic [ROW_W-1:0] NO_ROW = '1;

   logic [ROW_W-1:0]  row_q   [NB];
   logic [TW-1:0]     busy_q  [NB];
   logic [TW-1:0]     tras_q  [NB];
   logic [BYTE_W-1:0] bytes_q [NB];
   logic [ACC_W-1:0]  accs_q  [NB];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic hit_me;
      assign hit_me = wr_en && (wr_idx == IDX_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q[b]   <= NO_ROW;
            busy_q[b]  <= '0;
            tras_q[b]  <= '0;
            bytes_q[b] <= '0;
            accs_q[b]  <= '0;
         end else if (hit_me) begin
            row_q[b]   <= wr_row;
            busy_q[b]  <= wr_busy;
            tras_q[b]  <= wr_tras;
            bytes_q[b] <= wr_bytes;
            accs_q[b]  <= wr_accs;
         end
      end

      assign all_row[b*ROW_W +: ROW_W] = row_q[b];
      assign all_busy[b*TW +: TW]      = busy_q[b];
      assign all_tras[b*TW +: TW]      = tras_q[b];
   end

   assign rd_row   = row_q[rd_idx];
   assign rd_busy  = busy_q[rd_idx];
   assign rd_tras  = tras_q[rd_idx];
   assign rd_bytes = bytes_q[rd_idx];
   assign rd_accs  = accs_q[rd_idx];
endmodule

// File: rtl/bst_event_calc.sv
module bst_event_calc
   import bst_pkg::*;
#(
   parameter int ROW_W  = 14,
   parameter int TW     = 32,
   parameter int BYTE_W = 16,
   parameter int ACC_W  = 8,
   parameter int T_RCD  = 4,
   parameter int T_CL   = 5,
   parameter int T_RAS  = 10,
   parameter int T_RP   = 3
) (
   input  bst_op_e           op,
   input  logic              pol_closed,
   input  logic [ROW_W-1:0]  row,
   input  logic [TW-1:0]     now,
   input  logic [TW-1:0]     free_at,
   input  logic              auto_req,
   input  logic [BYTE_W-1:0] bytes,
   input  logic [ROW_W-1:0]  sel_row,
   input  logic [TW-1:0]     sel_busy,
   input  logic [TW-1:0]     sel_tras,
   input  logic [BYTE_W-1:0] sel_bytes,
   input  logic [ACC_W-1:0]  sel_accs,
   output logic              wr_en,
   output logic [ROW_W-1:0]  wr_row,
   output logic [TW-1:0]     wr_busy,
   output logic [TW-1:0]     wr_tras,
   output logic [BYTE_W-1:0] wr_bytes,
   output logic [ACC_W-1:0]  wr_accs,
   output logic              evict,
   output logic [TW-1:0]     evict_done,
   output logic              act_en,
   output logic [TW-1:0]     act_cyc,
   output logic              autop,
   output logic [TW-1:0]     auto_done
);
   localparam logic [ROW_W-1:0] NO_ROW = '1;
   localparam logic [TW-1:0]    LEAD   = TW'(T_CL + T_RCD);
   localparam logic [TW-1:0]    RAS_C  = TW'(T_RAS);
   localparam logic [TW-1:0]    RP_C   = TW'(T_RP);

   function automatic logic [TW-1:0] later(input logic [TW-1:0] a, input logic [TW-1:0] b);
      return (a > b) ? a : b;
   endfunction

   logic          is_acc, is_pre, is_open, hit, miss;
   logic [TW-1:0] tras_post;

   always_comb begin
      is_acc     = (op == OP_ACCESS);
      is_pre     = (op == OP_PRECHARGE);
      is_open    = (sel_row != NO_ROW);
      hit        = is_acc && is_open && !pol_closed && (sel_row == row);
      miss       = is_acc && !hit;
      evict      = is_open && (is_pre || miss);
      evict_done = later(later(sel_busy, sel_tras), now) + RP_C;
      act_en     = miss;
      act_cyc    = free_at - LEAD;
      tras_post  = miss ? (act_cyc + RAS_C) : sel_tras;
      autop      = is_acc && (auto_req || pol_closed);
      auto_done  = later(free_at, tras_post) + RP_C;
      wr_en      = is_acc || evict;

      if (is_acc) begin
         wr_row   = autop ? NO_ROW : row;
         wr_busy  = autop ? auto_done : free_at;
         wr_tras  = tras_post;
         wr_bytes = hit ? (sel_bytes + bytes) : bytes;
         wr_accs  = hit ? (sel_accs + ACC_W'(1)) : ACC_W'(1);
      end else begin
         wr_row   = NO_ROW;
         wr_busy  = evict_done;
         wr_tras  = sel_tras;
         wr_bytes = sel_bytes;
         wr_accs  = sel_accs;
      end
   end
endmodule

// File: rtl/bst_idle_acct.sv
module bst_idle_acct #(
   parameter int TW    = 32,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evict,
   input  logic [TW-1:0]    evict_done,
   input  logic             act_en,
   input  logic [TW-1:0]    act_cyc,
   input  logic             autop,
   input  logic [TW-1:0]    auto_done,
   output logic [CNT_W-1:0] count,
   output logic [TW-1:0]    since,
   output logic [TW-1:0]    total
);
   function automatic logic [TW-1:0] later(input logic [TW-1:0] a, input logic [TW-1:0] b);
      return (a > b) ? a : b;
   endfunction

   logic [CNT_W-1:0] c1, c2, c3;
   logic [TW-1:0]    s1, s2, gap;

   always_comb begin
      c1  = count - (evict ? CNT_W'(1) : CNT_W'(0));
      c2  = c1 + (act_en ? CNT_W'(1) : CNT_W'(0));
      c3  = c2 - (autop ? CNT_W'(1) : CNT_W'(0));
      s1  = (evict && c1 == '0) ? later(since, evict_done) : since;
      gap = (act_en && c1 == '0 && act_cyc > s1) ? (act_cyc - s1) : '0;
      s2  = (autop && c3 == '0) ? later(s1, auto_done) : s1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         since <= '0;
         total <= '0;
      end else begin
         count <= c3;
         since <= s2;
         total <= total + gap;
      end
   end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
   import bst_pkg::*;
#(
   parameter  int RANKS  = 2,
   parameter  int BANKS  = 4,
   parameter  int ROW_W  = 14,
   parameter  int TW     = 32,
   parameter  int BYTE_W = 16,
   parameter  int ACC_W  = 8,
   parameter  int T_RCD  = 4,
   parameter  int T_CL   = 5,
   parameter  int T_RAS  = 10,
   parameter  int T_RP   = 3,
   localparam int NB     = RANKS * BANKS,
   localparam int RK_W   = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int BK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1,
   localparam int CNT_W  = $clog2(NB + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pol_closed,
   input  logic [1:0]          cmd_op,
   input  logic [RK_W-1:0]     cmd_rank,
   input  logic [BK_W-1:0]     cmd_bank,
   input  logic [ROW_W-1:0]    cmd_row,
   input  logic [TW-1:0]       cmd_now,
   input  logic [TW-1:0]       cmd_free_at,
   input  logic                cmd_auto,
   input  logic [BYTE_W-1:0]   cmd_bytes,
   output logic [NB*ROW_W-1:0] bank_row,
   output logic [NB*TW-1:0]    bank_busy,
   output logic [NB*TW-1:0]    bank_tras,
   output logic [CNT_W-1:0]    act_count,
   output logic [TW-1:0]       idle_since,
   output logic [TW-1:0]       idle_total,
   output logic                evict_vld,
   output logic [BYTE_W-1:0]   evict_bytes,
   output logic [ACC_W-1:0]    evict_accs,
   output logic                auto_vld,
   output logic [BYTE_W-1:0]   auto_bytes,
   output logic [ACC_W-1:0]    auto_accs
);
   if (RANKS < 1 || BANKS < 2) begin : g_bad_geometry
      $error("dram_bank_tracker: need RANKS >= 1 and BANKS >= 2");
   end
   if (ROW_W < 2 || TW < 8 || ACC_W < 1 || BYTE_W < 1) begin : g_bad_width
      $error("dram_bank_tracker: field widths too small");
   end
   if (T_RAS < T_RCD || T_RP < 1 || T_CL < 1) begin : g_bad_timing
      $error("dram_bank_tracker: inconsistent timing parameters");
   end

   logic [IDX_W-1:0]  idx;
   logic [ROW_W-1:0]  sel_row;
   logic [TW-1:0]     sel_busy, sel_tras;
   logic [BYTE_W-1:0] sel_bytes;
   logic [ACC_W-1:0]  sel_accs;
   logic              wr_en;
   logic [ROW_W-1:0]  wr_row;
   logic [TW-1:0]     wr_busy, wr_tras;
   logic [BYTE_W-1:0] wr_bytes;
   logic [ACC_W-1:0]  wr_accs;
   logic              evict, act_en, autop;
   logic [TW-1:0]     evict_done, act_cyc, auto_done;

   assign idx = IDX_W'(cmd_rank) * IDX_W'(BANKS) + IDX_W'(cmd_bank);

   bst_bank_file #(
      .NB(NB), .IDX_W(IDX_W), .ROW_W(ROW_W), .TW(TW), .BYTE_W(BYTE_W), .ACC_W(ACC_W)
   ) u_banks (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(idx), .wr_row(wr_row), .wr_busy(wr_busy),
      .wr_tras(wr_tras), .wr_bytes(wr_bytes), .wr_accs(wr_accs),
      .rd_idx(idx), .rd_row(sel_row), .rd_busy(sel_busy), .rd_tras(sel_tras),
      .rd_bytes(sel_bytes), .rd_accs(sel_accs),
      .all_row(bank_row), .all_busy(bank_busy), .all_tras(bank_tras)
   );

   bst_event_calc #(
      .ROW_W(ROW_W), .TW(TW), .BYTE_W(BYTE_W), .ACC_W(ACC_W),
      .T_RCD(T_RCD), .T_CL(T_CL), .T_RAS(T_RAS), .T_RP(T_RP)
   ) u_calc (
      .op(bst_op_e'(cmd_op)), .pol_closed(pol_closed), .row(cmd_row), .now(cmd_now),
      .free_at(cmd_free_at), .auto_req(cmd_auto), .bytes(cmd_bytes),
      .sel_row(sel_row), .sel_busy(sel_busy), .sel_tras(sel_tras),
      .sel_bytes(sel_bytes), .sel_accs(sel_accs),
      .wr_en(wr_en), .wr_row(wr_row), .wr_busy(wr_busy), .wr_tras(wr_tras),
      .wr_bytes(wr_bytes), .wr_accs(wr_accs),
      .evict(evict), .evict_done(evict_done), .act_en(act_en), .act_cyc(act_cyc),
      .autop(autop), .auto_done(auto_done)
   );

   bst_idle_acct #(.TW(TW), .CNT_W(CNT_W)) u_idle (
      .clk(clk), .rst_n(rst_n),
      .evict(evict), .evict_done(evict_done), .act_en(act_en), .act_cyc(act_cyc),
      .autop(autop), .auto_done(auto_done),
      .count(act_count), .since(idle_since), .total(idle_total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evict_vld   <= 1'b0;
         evict_bytes <= '0;
         evict_accs  <= '0;
         auto_vld    <= 1'b0;
         auto_bytes  <= '0;
         auto_accs   <= '0;
      end else begin
         evict_vld   <= evict;
         evict_bytes <= sel_bytes;
         evict_accs  <= sel_accs;
         auto_vld    <= autop;
         auto_bytes  <= wr_bytes;
         auto_accs   <= wr_accs;
      end
   end
endmodule

// File: rtl/dram_bank_tracker_chk.sv
module dram_bank_tracker_chk #(
   parameter  int RANKS  = 2,
   parameter  int BANKS  = 4,
   parameter  int ROW_W  = 14,
   parameter  int TW     = 32,
   parameter  int T_RCD  = 4,
   parameter  int T_CL   = 5,
   localparam int NB     = RANKS * BANKS,
   localparam int RK_W   = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int BK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int CNT_W  = $clog2(NB + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pol_closed,
   input logic [1:0]          cmd_op,
   input logic [RK_W-1:0]     cmd_rank,
   input logic [BK_W-1:0]     cmd_bank,
   input logic [ROW_W-1:0]    cmd_row,
   input logic [TW-1:0]       cmd_now,
   input logic [TW-1:0]       cmd_free_at,
   input logic                cmd_auto,
   input logic [NB*ROW_W-1:0] bank_row,
   input logic [CNT_W-1:0]    act_count,
   input logic [TW-1:0]       idle_since,
   input logic [TW-1:0]       idle_total,
   input logic                evict_vld,
   input logic                auto_vld
);
   localparam logic [ROW_W-1:0] NO_ROW = '1;
   localparam logic [TW-1:0]    LEAD   = TW'(T_CL + T_RCD);

   int               sel_idx;
   logic [ROW_W-1:0] sel_row;

   always_comb begin
      sel_idx = int'(cmd_rank) * BANKS + int'(cmd_bank);
      sel_row = (sel_idx < NB) ? bank_row[sel_idx*ROW_W +: ROW_W] : NO_ROW;
   end

   // Input contract for accesses (R2)
   assert_access_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd1) |-> (cmd_row != NO_ROW && cmd_free_at >= cmd_now + LEAD));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      act_count <= CNT_W'(NB));

   assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (act_count <= $past(act_count) + CNT_W'(1)) &&
               ($past(act_count) <= act_count + CNT_W'(1)));

   assert_empty_close_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd2 && sel_row == NO_ROW) |=>
         ($stable(act_count) && !evict_vld && $stable(bank_row)));

   assert_auto_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd1 && cmd_auto) |=> auto_vld);

   assert_closed_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 2'd1 && pol_closed) |=> (auto_vld && act_count <= $past(act_count)));

   assert_evict_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evict_vld) |-> ($past(cmd_op) == 2'd1 || $past(cmd_op) == 2'd2));

   assert_since_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> idle_since >= $past(idle_since));

   assert_total_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> idle_total >= $past(idle_total));
endmodule

bind dram_bank_tracker dram_bank_tracker_chk #(
   .RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .TW(TW), .T_RCD(T_RCD), .T_CL(T_CL)
) u_chk (.*);

// File: tb/dram_bank_tracker_tb.sv
module dram_bank_tracker_tb;
   localparam int ROW_W = 14;
   localparam int TW    = 32;
   localparam int NB    = 8;
   localparam logic [ROW_W-1:0] NO_ROW = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pol_closed = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [0:0] cmd_rank = '0;
   logic [1:0] cmd_bank = '0;
   logic [ROW_W-1:0] cmd_row = '0;
   logic [TW-1:0] cmd_now = '0;
   logic [TW-1:0] cmd_free_at = '0;
   logic cmd_auto = 1'b0;
   logic [15:0] cmd_bytes = '0;
   logic [NB*ROW_W-1:0] bank_row;
   logic [NB*TW-1:0] bank_busy, bank_tras;
   logic [3:0] act_count;
   logic [TW-1:0] idle_since, idle_total;
   logic evict_vld, auto_vld;
   logic [15:0] evict_bytes, auto_bytes;
   logic [7:0] evict_accs, auto_accs;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dram_bank_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .pol_closed(pol_closed), .cmd_op(cmd_op),
      .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_now(cmd_now),
      .cmd_free_at(cmd_free_at), .cmd_auto(cmd_auto), .cmd_bytes(cmd_bytes),
      .bank_row(bank_row), .bank_busy(bank_busy), .bank_tras(bank_tras),
      .act_count(act_count), .idle_since(idle_since), .idle_total(idle_total),
      .evict_vld(evict_vld), .evict_bytes(evict_bytes), .evict_accs(evict_accs),
      .auto_vld(auto_vld), .auto_bytes(auto_bytes), .auto_accs(auto_accs)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic logic [ROW_W-1:0] row_of(input int i);
      return bank_row[i*ROW_W +: ROW_W];
   endfunction
   function automatic logic [TW-1:0] busy_of(input int i);
      return bank_busy[i*TW +: TW];
   endfunction
   function automatic logic [TW-1:0] tras_of(input int i);
      return bank_tras[i*TW +: TW];
   endfunction

   // Drives one event, lets the edge capture it, returns 1 time unit after the edge.
   task automatic issue(input logic [1:0] op, input int rk, input int bk, input int row,
                        input int now, input int free_at, input bit au, input int bytes);
      cmd_op = op; cmd_rank = 1'(rk); cmd_bank = 2'(bk); cmd_row = ROW_W'(row);
      cmd_now = TW'(now); cmd_free_at = TW'(free_at); cmd_auto = au; cmd_bytes = 16'(bytes);
      @(posedge clk); #1;
      cmd_op = 2'd0; cmd_auto = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < NB; i++) begin
         chk("R1 row empty", row_of(i), NO_ROW);
         chk("R1 busy zero", busy_of(i), 0);
         chk("R1 tras zero", tras_of(i), 0);
      end
      chk("R1 count", act_count, 0);
      chk("R1 since", idle_since, 0);
      chk("R1 total", idle_total, 0);
   endtask

   task automatic t_open_activate;
      issue(2'd1, 0, 1, 5, 50, 100, 0, 32);
      chk("R2 row", row_of(1), 5);
      chk("R2 busy", busy_of(1), 100);
      chk("R2 tras", tras_of(1), 101);
      chk("R2 count", act_count, 1);
      chk("R10 first gap", idle_total, 91);
   endtask

   task automatic t_row_hit;
      issue(2'd1, 0, 1, 5, 60, 110, 0, 32);
      chk("R3 busy", busy_of(1), 110);
      chk("R3 tras kept", tras_of(1), 101);
      chk("R3 row kept", row_of(1), 5);
      chk("R3 count kept", act_count, 1);
      chk("R3 no strobe", evict_vld, 0);
   endtask

   task automatic t_row_miss;
      issue(2'd1, 0, 1, 7, 70, 140, 0, 16);
      chk("R4 strobe", evict_vld, 1);
      chk("R4 bytes R3 accum", evict_bytes, 64);
      chk("R4 accs", evict_accs, 2);
      chk("R4 row", row_of(1), 7);
      chk("R4 busy", busy_of(1), 140);
      chk("R4 tras", tras_of(1), 141);
      chk("R4 count", act_count, 1);
      chk("R9 since at miss", idle_since, 113);
      chk("R10 miss gap", idle_total, 109);
   endtask

   task automatic t_close;
      issue(2'd2, 0, 1, 0, 150, 150, 0, 0);
      chk("R5 row", row_of(1), NO_ROW);
      chk("R5 busy", busy_of(1), 153);
      chk("R5 count", act_count, 0);
      chk("R5 strobe", evict_vld, 1);
      chk("R5 bytes", evict_bytes, 16);
      chk("R9 since", idle_since, 153);
   endtask

   task automatic t_close_empty;
      issue(2'd2, 1, 2, 0, 160, 160, 0, 0);
      chk("R6 row", row_of(6), NO_ROW);
      chk("R6 busy", busy_of(6), 0);
      chk("R6 count", act_count, 0);
      chk("R6 strobe", evict_vld, 0);
      chk("R6 since", idle_since, 153);
      chk("R6 total", idle_total, 109);
   endtask

   task automatic t_two_banks;
      issue(2'd1, 1, 0, 9, 160, 200, 0, 8);
      chk("R10 gap", idle_total, 147);
      chk("R2 count one", act_count, 1);
      issue(2'd1, 0, 0, 3, 165, 205, 0, 8);
      chk("R10 no gap while open", idle_total, 147);
      chk("R11 count two", act_count, 2);
   endtask

   task automatic t_auto;
      issue(2'd1, 1, 3, 2, 170, 220, 1, 4);
      chk("R7 row", row_of(7), NO_ROW);
      chk("R7 busy", busy_of(7), 224);
      chk("R7 tras", tras_of(7), 221);
      chk("R7 count", act_count, 2);
      chk("R7 strobe", auto_vld, 1);
      chk("R7 bytes", auto_bytes, 4);
      chk("R7 total", idle_total, 147);
   endtask

   task automatic t_closed_policy;
      issue(2'd2, 1, 0, 0, 230, 230, 0, 0);
      chk("R5 busy r1b0", busy_of(4), 233);
      issue(2'd2, 0, 0, 0, 231, 231, 0, 0);
      chk("R5 busy r0b0", busy_of(0), 234);
      chk("R9 since", idle_since, 234);
      pol_closed = 1'b1;
      issue(2'd1, 0, 2, 11, 240, 260, 0, 8);
      chk("R8 row empty", row_of(2), NO_ROW);
      chk("R8 busy", busy_of(2), 264);
      chk("R8 count", act_count, 0);
      chk("R8 strobe", auto_vld, 1);
      chk("R10 gap", idle_total, 164);
      chk("R9 since", idle_since, 264);
      issue(2'd1, 0, 2, 11, 250, 270, 0, 8);
      chk("R10 act before since", idle_total, 164);
      chk("R9 since later", idle_since, 274);
      chk("R8 busy again", busy_of(2), 274);
      pol_closed = 1'b0;
   endtask

   task automatic t_miss_auto;
      issue(2'd1, 1, 1, 4, 280, 300, 0, 2);
      chk("R10 gap", idle_total, 181);
      chk("R2 count", act_count, 1);
      issue(2'd1, 1, 1, 6, 290, 330, 1, 1);
      chk("R4 strobe", evict_vld, 1);
      chk("R4 bytes", evict_bytes, 2);
      chk("R7 strobe", auto_vld, 1);
      chk("R7 bytes", auto_bytes, 1);
      chk("R7 busy", busy_of(5), 334);
      chk("R7 row", row_of(5), NO_ROW);
      chk("R11 count", act_count, 0);
      chk("R10 gap after evict", idle_total, 198);
      chk("R9 since", idle_since, 334);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_open_activate();
      t_row_hit();
      t_row_miss();
      t_close();
      t_close_empty();
      t_two_banks();
      t_auto();
      t_closed_policy();
      t_miss_auto();
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog got 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule